// File: doc/BRIEF.md
# Interrupt and Exception Arbiter

This block sits beside an instruction sequencer and, on every instruction boundary, chooses the single pending event that the core will service next. It reports the winner as a one-cycle take strobe together with an 8-bit vector and a two-bit class code. The candidates are a pending fault, a software trap instruction, a debug trap raised by the instruction that just completed, a debug fault raised for the instruction about to start, a non-maskable request and a level-sensitive maskable request.

The arbiter holds the small amount of state that selection needs. It keeps an interrupt-enable flag that separate set and clear commands update. It tracks the non-maskable request: edge detection, a pending latch, and a block that starts when the request is taken and lasts until an interrupt return. It keeps a resume flag so that a restarted instruction raises its debug fault only once. It keeps a one-boundary shadow after a stack-segment load. Descriptor lookup, stacking and pipeline control belong to neighbouring logic. Those neighbours consume the take strobe, the vector and the class, and they acknowledge the external controller through the maskable acknowledge pulse.

Top module: `evt_arbiter`

## Requirements
- R1: A decision is made only in a cycle where `boundary_i` is 1. `take_o` is 1 for exactly the cycle after such a boundary when some candidate is eligible, and 0 otherwise. `vec_o`, `cls_o` and `intr_ack_o` are valid in that same cycle.
- R2: The class codes are: 0 = fault, 1 = trap, 2 = interrupt. A pending fault (`fault_i`) always wins, with vector `fault_vec_i` and class 0.
- R3: The priority order, from highest to lowest, is: fault, trap instruction, debug trap, debug fault, non-maskable, maskable. A trap instruction (`swint_i`) gives vector `swint_vec_i` and class 1.
- R4: A debug trap gives vector 1 with class 1. A debug fault gives vector 1 with class 0.
- R5: A rising edge on `nmi_i` makes a non-maskable request pending. It is serviced with vector 2 and class 2. A level held high does not raise a second request.
- R6: Once a non-maskable request is taken, no further one is taken until an `iret_i` pulse. An edge that arrives while blocked is latched and is serviced at the first eligible boundary after the return.
- R7: The maskable request is eligible only while the internal enable flag is 1. The flag is 0 after reset, `if_set_i` sets it and `if_clr_i` clears it, and clear wins when both are given. A command takes effect for boundaries in later cycles.
- R8: A taken maskable request gives vector `intr_vec_i` and class 2, and pulses `intr_ack_o` with `take_o`. A maskable request that loses to a higher event gets no acknowledge and is taken at a later boundary if still asserted.
- R9: A stack-segment load indication (`ss_load_i`), given in the boundary cycle or at any time since the previous boundary, suppresses debug traps, debug faults, non-maskable and maskable requests at the next boundary only. Faults and trap instructions are still taken at that boundary.
- R10: When a debug fault is taken, a resume flag is set. The flag masks `dbg_fault_i` at later boundaries and is cleared at the first boundary where `dbg_fault_i` is 0.
- R11: After reset, `take_o` and `intr_ack_o` are 0, no non-maskable request is pending or blocked, and the enable flag and resume flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| fault_i | input | 1 | Fault pending for the next instruction |
| fault_vec_i | input | 8 | Vector of the pending fault |
| swint_i | input | 1 | Trap instruction completed |
| swint_vec_i | input | 8 | Vector named by the trap instruction |
| dbg_trap_i | input | 1 | Debug trap of the completed instruction |
| dbg_fault_i | input | 1 | Debug fault for the next instruction |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| intr_vec_i | input | 8 | Vector of the maskable request |
| if_set_i | input | 1 | Set the enable flag |
| if_clr_i | input | 1 | Clear the enable flag |
| iret_i | input | 1 | Interrupt return pulse |
| ss_load_i | input | 1 | Stack-segment load indication |
| take_o | output | 1 | Event taken strobe |
| vec_o | output | 8 | Vector of the taken event |
| cls_o | output | 2 | Class of the taken event |
| intr_ack_o | output | 1 | Maskable request acknowledged |

## Verification
The interplay of most concern is a boundary where a non-maskable edge lands together with a stack-segment shadow or an interrupt return. The same applies when a maskable request arrives together with a fault that outranks it. The bench provokes these cases in directed sequences: an edge during the block followed by a return, a shadowed boundary with every low-priority source active, and a fault alongside a request. Random stimulus also makes these sources collide freely. Each boundary's outcome is predicted by a bench model of the pending, blocked, enable, resume and shadow state. The bench compares strobe, vector, class and acknowledge in the following cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;
   typedef enum logic [1:0] {
      EC_FAULT = 2'd0,
      EC_TRAP  = 2'd1,
      EC_INTR  = 2'd2
   } evt_cls_e;

   // priority levels, index 0 is the highest
   localparam int unsigned N_LVL     = 6;
   localparam int unsigned LV_FAULT  = 0;
   localparam int unsigned LV_SWTRAP = 1;
   localparam int unsigned LV_DTRAP  = 2;
   localparam int unsigned LV_DFAULT = 3;
   localparam int unsigned LV_NMI    = 4;
   localparam int unsigned LV_INTR   = 5;
endpackage

// File: rtl/evt_prio.sv
module evt_prio #(
   parameter int unsigned N     = 6,
   parameter int unsigned VEC_W = 8
) (
   input  logic [N-1:0]            req_i,
   input  logic [N-1:0][VEC_W-1:0] vec_i,
   input  logic [N-1:0][1:0]       cls_i,
   output logic                    any_o,
   output logic [N-1:0]            grant_o,
   output logic [VEC_W-1:0]        vec_o,
   output logic [1:0]              cls_o
);
   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      vec_o   = '0;
      cls_o   = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
      for (int i = 0; i < int'(N); i++) begin
         vec_o = vec_o | (grant_o[i] ? vec_i[i] : '0);
         cls_o = cls_o | (grant_o[i] ? cls_i[i] : 2'b00);
      end
      any_o = found;
   end
endmodule

// File: rtl/evt_nmi_trk.sv
module evt_nmi_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_i,
   input  logic iret_i,
   input  logic take_i,
   output logic avail_o
);
   logic lvl_q, pend_q, blk_q;
   logic rise_w;

   assign rise_w  = nmi_i & ~lvl_q;
   assign avail_o = (pend_q | rise_w) & ~blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         pend_q <= 1'b0;
         blk_q  <= 1'b0;
      end else begin
         lvl_q  <= nmi_i;
         pend_q <= take_i ? 1'b0 : (pend_q | rise_w);
         if (take_i)      blk_q <= 1'b1;
         else if (iret_i) blk_q <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_ctl.sv
module evt_ctl #(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary_i,
   input  logic if_set_i,
   input  logic if_clr_i,
   input  logic ss_load_i,
   input  logic dbg_fault_i,
   input  logic take_df_i,
   output logic if_o,
   output logic rf_o,
   output logic shadow_o
);
   logic if_q, rf_q, sh_q;
   logic if_d;

   generate
      if (CLR_WINS) begin : g_clr_first
         assign if_d = if_clr_i ? 1'b0 : (if_set_i ? 1'b1 : if_q);
      end else begin : g_set_first
         assign if_d = if_set_i ? 1'b1 : (if_clr_i ? 1'b0 : if_q);
      end
   endgenerate

   assign if_o     = if_q;
   assign rf_o     = rf_q;
   assign shadow_o = ss_load_i | sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_q <= 1'b0;
         rf_q <= 1'b0;
         sh_q <= 1'b0;
      end else begin
         if_q <= if_d;
         if (boundary_i) begin
            sh_q <= 1'b0;
            if (take_df_i)         rf_q <= 1'b1;
            else if (!dbg_fault_i) rf_q <= 1'b0;
         end else begin
            sh_q <= sh_q | ss_load_i;
         end
      end
   end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned NMI_VEC  = 2,
   parameter int unsigned DBG_VEC  = 1,
   parameter bit          CLR_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  logic             fault_i,
   input  logic [VEC_W-1:0] fault_vec_i,
   input  logic             swint_i,
   input  logic [VEC_W-1:0] swint_vec_i,
   input  logic             dbg_trap_i,
   input  logic             dbg_fault_i,
   input  logic             nmi_i,
   input  logic             intr_i,
   input  logic [VEC_W-1:0] intr_vec_i,
   input  logic             if_set_i,
   input  logic             if_clr_i,
   input  logic             iret_i,
   input  logic             ss_load_i,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [1:0]       cls_o,
   output logic             intr_ack_o
);
   import evt_pkg::*;

   localparam int unsigned N = N_LVL;

   generate
      if (VEC_W < 6) begin : g_bad_width
         $error("evt_arbiter: VEC_W must cover the reserved range");
      end
      if (NMI_VEC >= 32 || DBG_VEC >= 32) begin : g_bad_vec
         $error("evt_arbiter: fixed vectors must lie in the reserved range");
      end
   endgenerate

   logic                    if_w, rf_w, sh_w, nmi_av_w;
   logic [N-1:0]            req_w, grant_w;
   logic [N-1:0][VEC_W-1:0] vec_w;
   logic [N-1:0][1:0]       cls_w;
   logic                    any_w, sel_w, take_nmi_w, take_df_w;
   logic [VEC_W-1:0]        win_vec_w;
   logic [1:0]              win_cls_w;

   always_comb begin
      req_w            = '0;
      req_w[LV_FAULT]  = fault_i;
      req_w[LV_SWTRAP] = swint_i;
      req_w[LV_DTRAP]  = dbg_trap_i & ~sh_w;
      req_w[LV_DFAULT] = dbg_fault_i & ~rf_w & ~sh_w;
      req_w[LV_NMI]    = nmi_av_w & ~sh_w;
      req_w[LV_INTR]   = intr_i & if_w & ~sh_w;

      vec_w            = '0;
      vec_w[LV_FAULT]  = fault_vec_i;
      vec_w[LV_SWTRAP] = swint_vec_i;
      vec_w[LV_DTRAP]  = VEC_W'(DBG_VEC);
      vec_w[LV_DFAULT] = VEC_W'(DBG_VEC);
      vec_w[LV_NMI]    = VEC_W'(NMI_VEC);
      vec_w[LV_INTR]   = intr_vec_i;

      cls_w            = '0;
      cls_w[LV_FAULT]  = EC_FAULT;
      cls_w[LV_SWTRAP] = EC_TRAP;
      cls_w[LV_DTRAP]  = EC_TRAP;
      cls_w[LV_DFAULT] = EC_FAULT;
      cls_w[LV_NMI]    = EC_INTR;
      cls_w[LV_INTR]   = EC_INTR;
   end

   evt_prio #(.N(N), .VEC_W(VEC_W)) u_prio (
      .req_i   (req_w),
      .vec_i   (vec_w),
      .cls_i   (cls_w),
      .any_o   (any_w),
      .grant_o (grant_w),
      .vec_o   (win_vec_w),
      .cls_o   (win_cls_w)
   );

   assign sel_w      = boundary_i & any_w;
   assign take_nmi_w = sel_w & grant_w[LV_NMI];
   assign take_df_w  = sel_w & grant_w[LV_DFAULT];

   evt_nmi_trk u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_i   (nmi_i),
      .iret_i  (iret_i),
      .take_i  (take_nmi_w),
      .avail_o (nmi_av_w)
   );

   evt_ctl #(.CLR_WINS(CLR_WINS)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary_i),
      .if_set_i    (if_set_i),
      .if_clr_i    (if_clr_i),
      .ss_load_i   (ss_load_i),
      .dbg_fault_i (dbg_fault_i),
      .take_df_i   (take_df_w),
      .if_o        (if_w),
      .rf_o        (rf_w),
      .shadow_o    (sh_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o     <= 1'b0;
         intr_ack_o <= 1'b0;
         vec_o      <= '0;
         cls_o      <= '0;
      end else begin
         take_o     <= sel_w;
         intr_ack_o <= sel_w & grant_w[LV_INTR];
         if (sel_w) begin
            vec_o <= win_vec_w;
            cls_o <= win_cls_w;
         end
      end
   end
endmodule

// File: rtl/evt_arbiter_chk.sv
module evt_arbiter_chk #(
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned NMI_VEC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             boundary_i,
   input logic             intr_i,
   input logic             iret_i,
   input logic             take_o,
   input logic [VEC_W-1:0] vec_o,
   input logic [1:0]       cls_o,
   input logic             intr_ack_o
);
   logic nmi_take_w, blk_c;

   assign nmi_take_w = take_o && (cls_o == 2'd2) && !intr_ack_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          blk_c <= 1'b0;
      else if (iret_i)     blk_c <= 1'b0;
      else if (nmi_take_w) blk_c <= 1'b1;
   end

   assert_take_after_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i));

   assert_class_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (cls_o != 2'd3));

   assert_nmi_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_take_w |-> (vec_o == VEC_W'(NMI_VEC)));

   assert_nmi_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_take_w && blk_c));

   assert_ack_with_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      intr_ack_o |-> (take_o && cls_o == 2'd2));

   assert_ack_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      intr_ack_o |-> $past(intr_i));
endmodule

bind evt_arbiter evt_arbiter_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .boundary_i (boundary_i),
   .intr_i     (intr_i),
   .iret_i     (iret_i),
   .take_o     (take_o),
   .vec_o      (vec_o),
   .cls_o      (cls_o),
   .intr_ack_o (intr_ack_o)
);

// File: tb/evt_arbiter_tb.sv
module evt_arbiter_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boundary_i, fault_i, swint_i, dbg_trap_i, dbg_fault_i, nmi_i, intr_i;
   logic if_set_i, if_clr_i, iret_i, ss_load_i;
   logic [7:0] fault_vec_i, swint_vec_i, intr_vec_i;
   logic take_o, intr_ack_o;
   logic [7:0] vec_o;
   logic [1:0] cls_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // model state
   bit m_if, m_rf, m_sh, m_pend, m_blk, m_prev;

   always #4 clk = ~clk;

   evt_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
      .fault_i(fault_i), .fault_vec_i(fault_vec_i),
      .swint_i(swint_i), .swint_vec_i(swint_vec_i),
      .dbg_trap_i(dbg_trap_i), .dbg_fault_i(dbg_fault_i),
      .nmi_i(nmi_i), .intr_i(intr_i), .intr_vec_i(intr_vec_i),
      .if_set_i(if_set_i), .if_clr_i(if_clr_i), .iret_i(iret_i),
      .ss_load_i(ss_load_i),
      .take_o(take_o), .vec_o(vec_o), .cls_o(cls_o), .intr_ack_o(intr_ack_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic idle();
      boundary_i = 0; fault_i = 0; swint_i = 0; dbg_trap_i = 0; dbg_fault_i = 0;
      intr_i = 0; if_set_i = 0; if_clr_i = 0; iret_i = 0; ss_load_i = 0;
      fault_vec_i = 8'd13; swint_vec_i = 8'h80; intr_vec_i = 8'h40;
   endtask

   function automatic string lvl_tag(int lv);
      case (lv)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R10";
         4: return "R5";
         5: return "R8";
         default: return "R1";
      endcase
   endfunction

   // one clock: predict, advance, compare
   task automatic step(input string tag);
      bit rise, sh, nmi_av, e_take, e_ack;
      bit [5:0] req;
      int lv;
      logic [7:0] e_vec;
      logic [1:0] e_cls;
      string t;
      rise   = nmi_i && !m_prev;
      sh     = ss_load_i || m_sh;
      nmi_av = (m_pend || rise) && !m_blk;
      req[0] = fault_i;
      req[1] = swint_i;
      req[2] = dbg_trap_i && !sh;
      req[3] = dbg_fault_i && !m_rf && !sh;
      req[4] = nmi_av && !sh;
      req[5] = intr_i && m_if && !sh;
      lv = 6;
      for (int i = 5; i >= 0; i--) if (req[i]) lv = i;
      if (!boundary_i) lv = 6;
      e_take = (lv != 6);
      e_ack  = (lv == 5);
      case (lv)
         0: begin e_vec = fault_vec_i; e_cls = 2'd0; end
         1: begin e_vec = swint_vec_i; e_cls = 2'd1; end
         2: begin e_vec = 8'd1; e_cls = 2'd1; end
         3: begin e_vec = 8'd1; e_cls = 2'd0; end
         4: begin e_vec = 8'd2; e_cls = 2'd2; end
         5: begin e_vec = intr_vec_i; e_cls = 2'd2; end
         default: begin e_vec = 8'd0; e_cls = 2'd0; end
      endcase
      t = (tag == "") ? lvl_tag(lv) : tag;
      @(posedge clk);
      m_prev = nmi_i;
      m_pend = (lv == 4) ? 1'b0 : (m_pend || rise);
      if (lv == 4) m_blk = 1;
      else if (iret_i) m_blk = 0;
      if (if_clr_i) m_if = 0;
      else if (if_set_i) m_if = 1;
      if (boundary_i) begin
         m_sh = 0;
         if (lv == 3) m_rf = 1;
         else if (!dbg_fault_i) m_rf = 0;
      end else if (ss_load_i) m_sh = 1;
      @(negedge clk);
      checks = checks + 1;
      if (take_o !== e_take || intr_ack_o !== e_ack ||
          (e_take && (vec_o !== e_vec || cls_o !== e_cls))) begin
         fails = fails + 1;
         $display("FAIL %s: actual take=%0b vec=%0d cls=%0d ack=%0b expected take=%0b vec=%0d cls=%0d ack=%0b",
                  t, take_o, vec_o, cls_o, intr_ack_o, e_take, e_vec, e_cls, e_ack);
      end
   endtask

   task automatic bstep(input string tag);
      boundary_i = 1;
      step(tag);
      boundary_i = 0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      idle();
      nmi_i = 0;
      m_if = 0; m_rf = 0; m_sh = 0; m_pend = 0; m_blk = 0; m_prev = 0;
      repeat (3) @(negedge clk);
      checks = checks + 1;   // R11 reset state
      if (take_o !== 1'b0 || intr_ack_o !== 1'b0) begin
         fails = fails + 1;
         $display("FAIL R11: actual take=%0b ack=%0b expected take=0 ack=0", take_o, intr_ack_o);
      end
      rst_n = 1;
      @(negedge clk);

      // R11/R7: enable flag starts at 0, request ignored
      intr_i = 1; bstep("R11");
      if_set_i = 1; step("R7"); if_set_i = 0;
      bstep("R7");
      // R7: clear wins over set
      if_set_i = 1; if_clr_i = 1; step("R7"); if_set_i = 0; if_clr_i = 0;
      bstep("R7");
      if_set_i = 1; step("R7"); if_set_i = 0;

      // R8: request loses to a fault, then is taken later
      fault_i = 1; fault_vec_i = 8'd14; bstep("R8");
      fault_i = 0; intr_vec_i = 8'hC3; bstep("R8");

      // R3: peel the priority chain from the top
      fault_i = 1; swint_i = 1; dbg_trap_i = 1; dbg_fault_i = 1; nmi_i = 1;
      fault_vec_i = 8'd0; swint_vec_i = 8'd4;
      bstep("R3"); fault_i = 0;
      bstep("R3"); swint_i = 0;
      bstep("R4"); dbg_trap_i = 0;
      bstep("R4");                       // debug fault, resume flag set
      bstep("R10");                      // debug fault masked, NMI wins
      bstep("R6");                       // NMI blocked, maskable wins
      dbg_fault_i = 0; intr_i = 0;
      // R6: new edge while blocked is held until the return
      nmi_i = 0; step("R6"); nmi_i = 1; step("R6");
      bstep("R6");
      iret_i = 1; step("R6"); iret_i = 0;
      bstep("R6");
      bstep("R5");                       // level held: nothing further

      // R10: fault reappears after the flag has cleared
      dbg_fault_i = 1; bstep("R10");
      dbg_fault_i = 0; bstep("R10");
      dbg_fault_i = 1; bstep("R10"); dbg_fault_i = 0;

      // R9: shadow after a stack-segment load
      nmi_i = 0; step("R9");
      iret_i = 1; step("R9"); iret_i = 0;
      ss_load_i = 1; step("R9"); ss_load_i = 0;
      dbg_trap_i = 1; intr_i = 1; nmi_i = 1;
      bstep("R9");
      swint_i = 1; ss_load_i = 1; bstep("R9"); swint_i = 0; ss_load_i = 0;
      bstep("R9");
      idle();

      // constrained random mix
      for (int n = 0; n < 6000; n++) begin
         boundary_i  = ($urandom % 3) == 0;
         fault_i     = ($urandom % 10) == 0;
         fault_vec_i = 8'($urandom % 32);
         swint_i     = ($urandom % 10) == 0;
         swint_vec_i = 8'($urandom);
         dbg_trap_i  = ($urandom % 12) == 0;
         if (($urandom % 6) == 0) dbg_fault_i = ~dbg_fault_i;
         if (($urandom % 20) == 0) nmi_i = ~nmi_i;
         intr_i      = ($urandom % 3) == 0;
         intr_vec_i  = 8'(32 + ($urandom % 224));
         if_set_i    = ($urandom % 15) == 0;
         if_clr_i    = ($urandom % 20) == 0;
         iret_i      = ($urandom % 15) == 0;
         ss_load_i   = ($urandom % 15) == 0;
         step("");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule